// File: doc/BRIEF.md
# Serial Configuration Port (Device Side)

This block models the receiving end of a one-bit-wide serial configuration link on a programmable device. It has two modes: configuration and user. While the active-low program pin is held low, and again after it is released, the block stays in configuration mode. In that mode the user I/O is disabled, the init line is pulled low and the done line is pulled low. Once the program pin is released, a settling timer runs. When it expires, the init line is released and the block starts accepting bitstream bits.

Bits arrive on a valid/ready stream, one per rising edge of the configuration clock. A bit is taken only on an edge where both `in_valid` and `in_ready` are high. `in_ready` is low while the block settles and once it is in user mode, so the sender must hold a bit until ready is high. A low ready is back-pressure, and bits offered while it is low are dropped. After the expected number of bits has been taken, the block enters user mode. It then releases the done line, enables the user I/O and presents the loaded word. Pulling the program pin low at any moment stops user operation at once and discards what was loaded.

The init and done lines are open-drain. The block drives each one only low, so it reports each line as a pull-low enable: a 1 means the line is held low, and a 0 means it is released.

Top module: `serial_cfg_port`

## Requirements
- R1: While `prog_n` is low: `init_pull`=1, `done_pull`=1, `user_oe`=0, `in_ready`=0 and `user_io_val`=0.
- R2: After `prog_n` rises, `init_pull` stays 1 for exactly SETTLE_CYCLES rising edges of `cfg_clk`. After the SETTLE_CYCLES-th edge it is 0 and `in_ready` is 1.
- R3: A bit is taken only on an edge where `in_valid` and `in_ready` are both 1. Bits offered during settling, and idle cycles with `in_valid`=0, do not change the loaded word or the bit count.
- R4: Bits are shifted in MSB first. The first bit taken appears at bit STREAM_BITS-1 of `user_io_val`, and the last bit taken appears at bit 0.
- R5: After STREAM_BITS-1 bits have been taken, `user_oe`=0 and `done_pull`=1. Directly after the edge that takes bit STREAM_BITS, `user_oe`=1, `done_pull`=0 and `user_io_val` equals the loaded word.
- R6: In user mode `in_ready`=0, and further offered bits leave `user_io_val` unchanged.
- R7: Lowering `prog_n` drops `user_oe` and sets `done_pull` and `init_pull` without waiting for a clock edge. It discards both a finished load and a partial load, so a new load after release yields exactly the newly sent word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cfg_clk | input | 1 | Configuration clock; bits are taken on its rising edge |
| prog_n | input | 1 | Active-low program pin; asynchronous reset of the whole port |
| in_valid | input | 1 | A bitstream bit is offered |
| in_data | input | 1 | Bitstream bit |
| in_ready | output | 1 | Port accepts a bit on the next rising edge |
| init_pull | output | 1 | 1 = holding the open-drain init line low |
| done_pull | output | 1 | 1 = holding the open-drain done line low |
| user_oe | output | 1 | Output enable for user I/O (0 = tri-stated) |
| user_io_val | output | STREAM_BITS | Loaded word in user mode, zero otherwise |

## Verification
The assertions assume that `prog_n`, `in_valid` and `in_data` never change at a rising edge of `cfg_clk`. They also assume that a release of `prog_n` is followed by clock edges, so that the settling count measured in the checker starts from the first edge after release. The bench changes every input only at the falling edge, or a short delay after it. It checks the immediate effect of the program pin before any rising edge comes. It sweeps every word of a reduced-size port, offers bits during settling, inserts idle gaps and aborts partial loads.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  typedef enum logic [1:0] {
    MODE_SETTLE = 2'd0,
    MODE_LOAD   = 2'd1,
    MODE_USER   = 2'd2
  } port_mode_t;
endpackage

// File: rtl/cfgp_settle_timer.sv
module cfgp_settle_timer #(
  parameter int SETTLE_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int CW = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYCLES - 1);

  logic [CW-1:0] tick_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= '0;
    end else if (run && tick_q != LAST) begin
      tick_q <= tick_q + 1'b1;
    end
  end

  assign expired = run && (tick_q == LAST);
endmodule

// File: rtl/cfgp_bit_collector.sv
module cfgp_bit_collector #(
  parameter int STREAM_BITS = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   take,
  input  logic                   bit_in,
  output logic [STREAM_BITS-1:0] word,
  output logic                   at_last
);
  localparam int NW = $clog2(STREAM_BITS + 1);
  localparam logic [NW-1:0] FINAL = NW'(STREAM_BITS - 1);

  logic [STREAM_BITS-1:0] shift_q;
  logic [NW-1:0]          seen_q;

  generate
    if (STREAM_BITS == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    shift_q <= '0;
        else if (take) shift_q <= bit_in;
      end
    end else begin : g_shift
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    shift_q <= '0;
        else if (take) shift_q <= {shift_q[STREAM_BITS-2:0], bit_in};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    seen_q <= '0;
    else if (take) seen_q <= seen_q + 1'b1;
  end

  assign word    = shift_q;
  assign at_last = (seen_q == FINAL);
endmodule

// File: rtl/cfgp_mode_fsm.sv
module cfgp_mode_fsm
  import cfgp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       settle_done,
  input  logic       final_take,
  output port_mode_t mode
);
  port_mode_t mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      MODE_SETTLE: if (settle_done) mode_d = MODE_LOAD;
      MODE_LOAD:   if (final_take)  mode_d = MODE_USER;
      MODE_USER:   mode_d = MODE_USER;
      default:     mode_d = MODE_SETTLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_SETTLE;
    else        mode_q <= mode_d;
  end

  assign mode = mode_q;
endmodule

// File: rtl/serial_cfg_port.sv
module serial_cfg_port
  import cfgp_pkg::*;
#(
  parameter int SETTLE_CYCLES = 8,
  parameter int STREAM_BITS   = 16
) (
  input  logic                   cfg_clk,
  input  logic                   prog_n,
  input  logic                   in_valid,
  input  logic                   in_data,
  output logic                   in_ready,
  output logic                   init_pull,
  output logic                   done_pull,
  output logic                   user_oe,
  output logic [STREAM_BITS-1:0] user_io_val
);
  port_mode_t             mode;
  logic                   settle_done;
  logic                   take;
  logic                   at_last;
  logic [STREAM_BITS-1:0] word;

  cfgp_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_timer (
    .clk     (cfg_clk),
    .rst_n   (prog_n),
    .run     (mode == MODE_SETTLE),
    .expired (settle_done)
  );

  assign in_ready = prog_n && (mode == MODE_LOAD);
  assign take     = in_valid && in_ready;

  cfgp_bit_collector #(.STREAM_BITS(STREAM_BITS)) u_collect (
    .clk     (cfg_clk),
    .rst_n   (prog_n),
    .take    (take),
    .bit_in  (in_data),
    .word    (word),
    .at_last (at_last)
  );

  cfgp_mode_fsm u_fsm (
    .clk         (cfg_clk),
    .rst_n       (prog_n),
    .settle_done (settle_done),
    .final_take  (take && at_last),
    .mode        (mode)
  );

  assign user_oe     = prog_n && (mode == MODE_USER);
  assign user_io_val = user_oe ? word : '0;
  assign init_pull   = !prog_n || (mode == MODE_SETTLE);
  assign done_pull   = !user_oe;
endmodule

// File: rtl/cfgp_checker.sv
module cfgp_checker #(
  parameter int SETTLE_CYCLES = 8,
  parameter int STREAM_BITS   = 16
) (
  input logic                   cfg_clk,
  input logic                   prog_n,
  input logic                   in_valid,
  input logic                   in_ready,
  input logic                   init_pull,
  input logic                   done_pull,
  input logic                   user_oe,
  input logic [STREAM_BITS-1:0] user_io_val
);
  int unsigned since_rel;

  always_ff @(posedge cfg_clk or negedge prog_n) begin
    if (!prog_n)                             since_rel <= 0;
    else if (since_rel < SETTLE_CYCLES + 1)  since_rel <= since_rel + 1;
  end

  assert_ready_after_init_R2: assert property (@(posedge cfg_clk) disable iff (!prog_n)
    in_ready |-> !init_pull);

  assert_settle_length_R2: assert property (@(posedge cfg_clk) disable iff (!prog_n)
    $fell(init_pull) |-> (since_rel == SETTLE_CYCLES));

  assert_idle_outputs_R1: assert property (@(posedge cfg_clk) disable iff (!prog_n)
    !user_oe |-> (user_io_val == '0) && done_pull);

  assert_entry_on_take_R5: assert property (@(posedge cfg_clk) disable iff (!prog_n)
    $rose(user_oe) |-> $past(in_valid && in_ready));

  assert_user_hold_R6: assert property (@(posedge cfg_clk) disable iff (!prog_n)
    user_oe |=> user_oe && $stable(user_io_val));

  assert_no_ready_user_R6: assert property (@(posedge cfg_clk) disable iff (!prog_n)
    user_oe |-> !in_ready);

  always @(negedge cfg_clk) begin
    if (!prog_n) begin
      assert_prog_stops_R7: assert (!user_oe && done_pull && init_pull && !in_ready);
    end
  end
endmodule

bind serial_cfg_port cfgp_checker #(
  .SETTLE_CYCLES(SETTLE_CYCLES),
  .STREAM_BITS  (STREAM_BITS)
) u_chk (
  .cfg_clk     (cfg_clk),
  .prog_n      (prog_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .init_pull   (init_pull),
  .done_pull   (done_pull),
  .user_oe     (user_oe),
  .user_io_val (user_io_val)
);

// File: tb/serial_cfg_port_test.sv
`timescale 1ns/1ps
module serial_cfg_port_test;
  localparam int S = 4;
  localparam int W = 8;

  logic         cfg_clk = 1'b0;
  logic         prog_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_data = 1'b0;
  logic         in_ready, init_pull, done_pull, user_oe;
  logic [W-1:0] user_io_val;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 cfg_clk = ~cfg_clk;

  serial_cfg_port #(.SETTLE_CYCLES(S), .STREAM_BITS(W)) uut (
    .cfg_clk(cfg_clk), .prog_n(prog_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .init_pull(init_pull), .done_pull(done_pull),
    .user_oe(user_oe), .user_io_val(user_io_val)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic hold_program();
    @(negedge cfg_clk);
    prog_n = 1'b0; in_valid = 1'b0;
    #1;
    chk(init_pull == 1 && done_pull == 1, "R1 lines pulled", {init_pull, done_pull}, 2'b11);
    chk(user_oe == 0 && in_ready == 0 && user_io_val == 0, "R1 io idle",
        {user_oe, in_ready, user_io_val}, 0);
    repeat (2) @(negedge cfg_clk);
    prog_n = 1'b1;
    in_valid = 1'b1; in_data = 1'b1;    // R3: offered during settling, must be dropped
    for (int k = 1; k <= S; k++) begin
      @(negedge cfg_clk);
      chk(init_pull == (k < S), "R2 init timing", init_pull, (k < S));
      chk(in_ready == (k >= S), "R2 ready timing", in_ready, (k >= S));
    end
    in_valid = 1'b0;
  endtask

  task automatic send_bit(input logic b, input bit gap);
    if (gap) begin
      in_valid = 1'b0; in_data = ~b;    // R3: idle cycle
      @(negedge cfg_clk);
    end
    in_valid = 1'b1; in_data = b;
    @(negedge cfg_clk);
    in_valid = 1'b0;
  endtask

  initial begin
    for (int p = 0; p < (1 << W); p++) begin
      hold_program();
      if (p % 32 == 9) begin
        for (int i = 0; i < 3; i++) send_bit(1'b1, 1'b0);   // partial load, aborted
        hold_program();                                      // R7 discard
      end
      for (int i = W - 1; i >= 0; i--) begin
        send_bit(p[i], ((p + i) % 3) == 0);
        if (i > 0)
          chk(user_oe == 0 && done_pull == 1, "R5 not yet user", {user_oe, done_pull}, 2'b01);
      end
      chk(user_oe == 1 && done_pull == 0, "R5 user entry", {user_oe, done_pull}, 2'b10);
      chk(user_io_val == W'(p), "R4 MSB-first word", user_io_val, p);
      for (int j = 0; j < 3; j++) begin
        in_valid = 1'b1; in_data = ~in_data;
        #1;
        chk(in_ready == 0, "R6 no ready in user", in_ready, 0);
        @(negedge cfg_clk);
        chk(user_io_val == W'(p) && user_oe == 1, "R6 word held", user_io_val, p);
      end
      in_valid = 1'b0;
      if (p % 16 == 5) begin
        #3 prog_n = 1'b0;
        #1;
        chk(user_oe == 0 && done_pull == 1 && init_pull == 1, "R7 immediate stop",
            {user_oe, done_pull, init_pull}, 3'b011);
        chk(user_io_val == 0, "R7 io cleared", user_io_val, 0);
      end
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge cfg_clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule